// File: doc/BRIEF.md
# Port-Triggered Watchdog Timer

This block is a system watchdog for a small board computer. It watches the I/O read strobe and the decoded I/O address. A read from the arm port (0x443) starts the watchdog, and later reads from that same port restart its count. A read from the disarm port (0x043) stops the watchdog. Software keeps the system alive by reading the arm port again before the chosen period has gone by.

The period and the action on expiry are static strap inputs, as jumpers would be. Counting advances on a 1 Hz tick that is one clock cycle wide. When the count runs out, the block drives a reset pulse, an NMI pulse, or nothing, for a fixed number of clock cycles. It then returns to the disarmed state.

Top module: `port_watchdog`

## Requirements
- R1: After reset the watchdog is disarmed and both `rst_pulse_o` and `nmi_pulse_o` are low. Ticks while disarmed never cause an expiry.
- R2: A cycle with `io_rd` high and `io_addr` = 0x443 arms a disarmed watchdog with its tick count at zero.
- R3: The same read while armed clears the count to zero. When it coincides with a tick, the clear wins and that tick is not counted.
- R4: A cycle with `io_rd` high and `io_addr` = 0x043 disarms the watchdog and clears its count. No expiry follows until the watchdog is armed again.
- R5: `period_sel` maps to a period in ticks: 0→1, 1→2, 2→10, 3→20, 4→110, 5→220. Codes 6 and 7 give 1.
- R6: An armed watchdog expires on the N-th tick after it was armed or last refreshed, where N is the selected period, provided no refresh or disarm arrives in between.
- R7: `action_sel` decides the output on expiry: 2'b00 pulses `rst_pulse_o`, 2'b01 pulses `nmi_pulse_o`, and 2'b10 or 2'b11 drives neither output. At most one output is ever high.
- R8: The selected output rises in the clock cycle after the expiring tick and stays high for exactly 16 cycles. After an expiry the watchdog is disarmed.
- R9: The count is compared with the period currently selected. If `period_sel` changes while the watchdog is armed and the count has already reached the new period, the next tick expires the watchdog.
- R10: A read of any other address, or either port address without `io_rd`, changes neither the armed state nor the count.
- R11: When a disarm read and an expiring tick fall in the same cycle, the disarm wins and no pulse is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_rd | input | 1 | I/O read strobe, one cycle per access |
| io_addr | input | 16 | Decoded I/O address |
| sec_tick | input | 1 | 1 Hz count tick, one cycle wide |
| period_sel | input | 3 | Timeout period code |
| action_sel | input | 2 | Expiry action code |
| rst_pulse_o | output | 1 | System reset pulse |
| nmi_pulse_o | output | 1 | NMI pulse |

## Verification
The assertions assume that each I/O access is a single-cycle `io_rd` strobe and that `sec_tick` is never high for two cycles in a row. They also assume that the strap inputs change only when the bench changes them on purpose. The stimulus drives every strobe and tick for exactly one cycle, with at least one idle cycle between ticks. It changes `period_sel` and `action_sel` only between accesses, so the reference model and the assertions see the same well-formed traffic.

// File: rtl/pwd_pkg.sv
package pwd_pkg;

  localparam int CNT_W = 8;

  typedef enum logic [1:0] {
    ACT_RESET = 2'b00,
    ACT_NMI   = 2'b01,
    ACT_OFF_A = 2'b10,
    ACT_OFF_B = 2'b11
  } act_e;

  typedef struct packed {
    logic arm;
    logic disarm;
  } hit_t;

  function automatic logic [CNT_W-1:0] period_limit(input logic [2:0] sel);
    logic [CNT_W-1:0] lim;
    case (sel)
      3'd1:    lim = CNT_W'(2);
      3'd2:    lim = CNT_W'(10);
      3'd3:    lim = CNT_W'(20);
      3'd4:    lim = CNT_W'(110);
      3'd5:    lim = CNT_W'(220);
      default: lim = CNT_W'(1);
    endcase
    return lim;
  endfunction

endpackage

// File: rtl/pwd_decode.sv
module pwd_decode #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] ARM_ADDR    = 'h443,
  parameter logic [ADDR_W-1:0] DISARM_ADDR = 'h043
) (
  input  logic              io_rd,
  input  logic [ADDR_W-1:0] io_addr,
  output pwd_pkg::hit_t     hits
);
  always_comb begin
    hits.arm    = io_rd && (io_addr == ARM_ADDR);
    hits.disarm = io_rd && (io_addr == DISARM_ADDR);
  end
endmodule

// File: rtl/pwd_counter.sv
module pwd_counter (
  input  logic          clk,
  input  logic          rst,
  input  pwd_pkg::hit_t hits,
  input  logic          sec_tick,
  input  logic [2:0]    period_sel,
  output logic          armed,
  output logic          expire
);
  import pwd_pkg::*;

  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] limit;
  logic [CNT_W:0]   next_cnt;
  logic             at_limit;

  always_comb begin
    limit    = period_limit(period_sel);
    next_cnt = {1'b0, count_q} + 1'b1;
    at_limit = next_cnt >= {1'b0, limit};
    // a clear (disarm or refresh) always beats an expiring tick
    expire   = armed && sec_tick && !hits.disarm && !hits.arm && at_limit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed   <= 1'b0;
      count_q <= '0;
    end else if (hits.disarm) begin
      armed   <= 1'b0;
      count_q <= '0;
    end else if (hits.arm) begin
      armed   <= 1'b1;
      count_q <= '0;
    end else if (armed && sec_tick) begin
      if (at_limit) begin
        armed   <= 1'b0;
        count_q <= '0;
      end else begin
        count_q <= next_cnt[CNT_W-1:0];
      end
    end
  end
endmodule

// File: rtl/pwd_pulse.sv
module pwd_pulse #(
  parameter int PULSE_LEN = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          expire,
  input  pwd_pkg::act_e action,
  output logic          rst_q,
  output logic          nmi_q
);
  import pwd_pkg::*;

  localparam int LEN_W = (PULSE_LEN > 1) ? $clog2(PULSE_LEN) : 1;

  logic [LEN_W-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rst_q  <= 1'b0;
      nmi_q  <= 1'b0;
      left_q <= '0;
    end else if (expire) begin
      rst_q  <= (action == ACT_RESET);
      nmi_q  <= (action == ACT_NMI);
      left_q <= LEN_W'(PULSE_LEN - 1);
    end else if (left_q != '0) begin
      left_q <= left_q - 1'b1;
    end else begin
      rst_q <= 1'b0;
      nmi_q <= 1'b0;
    end
  end
endmodule

// File: rtl/port_watchdog.sv
module port_watchdog #(
  parameter int ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] ARM_ADDR    = 'h443,
  parameter logic [ADDR_W-1:0] DISARM_ADDR = 'h043,
  parameter int PULSE_LEN = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              io_rd,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              sec_tick,
  input  logic [2:0]        period_sel,
  input  logic [1:0]        action_sel,
  output logic              rst_pulse_o,
  output logic              nmi_pulse_o
);
  import pwd_pkg::*;

  hit_t hits;
  logic armed;
  logic expire;

  pwd_decode #(
    .ADDR_W(ADDR_W), .ARM_ADDR(ARM_ADDR), .DISARM_ADDR(DISARM_ADDR)
  ) decode_i (
    .io_rd(io_rd), .io_addr(io_addr), .hits(hits)
  );

  pwd_counter counter_i (
    .clk(clk), .rst(rst), .hits(hits), .sec_tick(sec_tick),
    .period_sel(period_sel), .armed(armed), .expire(expire)
  );

  pwd_pulse #(.PULSE_LEN(PULSE_LEN)) pulse_i (
    .clk(clk), .rst(rst), .expire(expire), .action(act_e'(action_sel)),
    .rst_q(rst_pulse_o), .nmi_q(nmi_pulse_o)
  );
endmodule

// File: rtl/port_watchdog_chk.sv
module port_watchdog_chk #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] ARM_ADDR    = 'h443,
  parameter logic [ADDR_W-1:0] DISARM_ADDR = 'h043
) (
  input logic              clk,
  input logic              rst,
  input logic              io_rd,
  input logic [ADDR_W-1:0] io_addr,
  input logic              sec_tick,
  input logic              armed,
  input logic              rst_pulse_o,
  input logic              nmi_pulse_o
);
  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (!armed && !rst_pulse_o && !nmi_pulse_o)); // R1

  AST_ARM_READ: assert property (@(posedge clk) disable iff (rst)
    (io_rd && io_addr == ARM_ADDR) |=> armed); // R2

  AST_DISARM_READ: assert property (@(posedge clk) disable iff (rst)
    (io_rd && io_addr == DISARM_ADDR) |=> !armed); // R4

  AST_ONE_OUTPUT: assert property (@(posedge clk) disable iff (rst)
    !(rst_pulse_o && nmi_pulse_o)); // R7

  AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (rst)
    ($rose(rst_pulse_o) || $rose(nmi_pulse_o)) |-> $past(armed && sec_tick)); // R6

  AST_EXPIRY_DISARMS: assert property (@(posedge clk) disable iff (rst)
    ($rose(rst_pulse_o) || $rose(nmi_pulse_o)) |-> !armed); // R8

  AST_DISARM_WINS: assert property (@(posedge clk) disable iff (rst)
    (io_rd && io_addr == DISARM_ADDR) |=> (!$rose(rst_pulse_o) && !$rose(nmi_pulse_o))); // R11
endmodule

bind port_watchdog port_watchdog_chk #(
  .ADDR_W(ADDR_W), .ARM_ADDR(ARM_ADDR), .DISARM_ADDR(DISARM_ADDR)
) chk_i (
  .clk(clk), .rst(rst), .io_rd(io_rd), .io_addr(io_addr), .sec_tick(sec_tick),
  .armed(armed), .rst_pulse_o(rst_pulse_o), .nmi_pulse_o(nmi_pulse_o)
);

// File: tb/port_watchdog_tb_top.sv
`timescale 1ns/1ps
module port_watchdog_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        io_rd = 1'b0;
  logic [15:0] io_addr = '0;
  logic        sec_tick = 1'b0;
  logic [2:0]  period_sel = '0;
  logic [1:0]  action_sel = '0;
  logic        rst_pulse_o, nmi_pulse_o;

  int    checks = 0;
  int    errors = 0;
  bit    done = 0;
  string phase = "R1";

  localparam logic [15:0] A_ARM = 16'h0443;
  localparam logic [15:0] A_DIS = 16'h0043;

  always #2.5 clk = ~clk;

  port_watchdog dut_i (
    .clk(clk), .rst(rst), .io_rd(io_rd), .io_addr(io_addr), .sec_tick(sec_tick),
    .period_sel(period_sel), .action_sel(action_sel),
    .rst_pulse_o(rst_pulse_o), .nmi_pulse_o(nmi_pulse_o)
  );

  // reference model state
  bit m_armed;
  int m_ticks;
  int m_remain;
  int m_kind;

  function automatic int period_ticks(input int code);
    case (code)
      1: return 2;
      2: return 10;
      3: return 20;
      4: return 110;
      5: return 220;
      default: return 1;
    endcase
  endfunction

  always @(posedge clk) begin
    bit fired;
    fired = 0;
    if (rst) begin
      m_armed = 0; m_ticks = 0; m_remain = 0; m_kind = 0;
    end else begin
      if (io_rd && io_addr == A_DIS) begin
        m_armed = 0; m_ticks = 0;
      end else if (io_rd && io_addr == A_ARM) begin
        m_armed = 1; m_ticks = 0;
      end else if (m_armed && sec_tick) begin
        m_ticks++;
        if (m_ticks >= period_ticks(int'(period_sel))) begin
          fired = 1; m_armed = 0; m_ticks = 0;
        end
      end
      if (fired) begin
        m_remain = 16; m_kind = int'(action_sel);
      end else if (m_remain > 0) begin
        m_remain--;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(rst_pulse_o === (m_remain > 0 && m_kind == 0), phase, int'(rst_pulse_o),
          int'(m_remain > 0 && m_kind == 0));
      chk(nmi_pulse_o === (m_remain > 0 && m_kind == 1), phase, int'(nmi_pulse_o),
          int'(m_remain > 0 && m_kind == 1));
    end
  end

  task automatic step(input logic rd, input logic [15:0] addr, input logic tk);
    io_rd = rd; io_addr = addr; sec_tick = tk;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 16'h0, 0);
  endtask

  task automatic tick_n(input int n);
    for (int i = 0; i < n; i++) begin
      step(0, 16'h0, 1);
      step(0, 16'h0, 0);
    end
  endtask

  task automatic ticks_to_expire(input int maxn, output int n, output bit seen);
    n = 0; seen = 0;
    for (int i = 0; i < maxn; i++) begin
      step(0, 16'h0, 1);
      n++;
      if (rst_pulse_o || nmi_pulse_o) begin
        seen = 1;
        break;
      end
      step(0, 16'h0, 0);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      finish_run();
    end
  end

  initial begin
    int  n;
    bit  seen;
    int  hi;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    step(0, 16'h0, 0);

    // R1: reset state and ticks while disarmed
    phase = "R1";
    chk(rst_pulse_o == 0 && nmi_pulse_o == 0, "R1", int'(rst_pulse_o | nmi_pulse_o), 0);
    ticks_to_expire(5, n, seen);
    chk(!seen, "R1", int'(seen), 0);

    // R10: junk accesses leave a disarmed watchdog disarmed
    phase = "R10";
    step(1, 16'h0442, 0); step(1, 16'h1443, 0); step(0, A_ARM, 0);
    ticks_to_expire(4, n, seen);
    chk(!seen, "R10", int'(seen), 0);

    // R2 R6 R7 R8: arm, 1-tick period, reset action, pulse length
    phase = "R8";
    period_sel = 3'd0; action_sel = 2'b00;
    step(1, A_ARM, 0);
    ticks_to_expire(5, n, seen);
    chk(seen && n == 1, "R2", n, 1);
    chk(rst_pulse_o == 1 && nmi_pulse_o == 0, "R7", int'(rst_pulse_o), 1);
    hi = 1;
    for (int i = 0; i < 24; i++) begin
      step(0, 16'h0, 0);
      if (rst_pulse_o) hi++;
    end
    chk(hi == 16, "R8", hi, 16);
    ticks_to_expire(4, n, seen);
    chk(!seen, "R8", int'(seen), 0);

    // R5 R6: every period code with the NMI action
    phase = "R5";
    action_sel = 2'b01;
    for (int c = 0; c < 8; c++) begin
      period_sel = 3'(c);
      step(1, A_ARM, 0);
      ticks_to_expire(300, n, seen);
      chk(seen && n == period_ticks(c), "R5", n, period_ticks(c));
      chk(nmi_pulse_o == 1, "R6", int'(nmi_pulse_o), 1);
      idle(20);
    end

    // R3: refresh restarts the count, also when it meets a tick
    phase = "R3";
    period_sel = 3'd2;
    step(1, A_ARM, 0);
    tick_n(9);
    step(1, A_ARM, 0);
    ticks_to_expire(20, n, seen);
    chk(seen && n == 10, "R3", n, 10);
    idle(20);
    step(1, A_ARM, 0);
    tick_n(9);
    step(1, A_ARM, 1);
    step(0, 16'h0, 0);
    ticks_to_expire(20, n, seen);
    chk(seen && n == 10, "R3", n, 10);
    idle(20);

    // R10: junk accesses while armed neither refresh nor disarm
    phase = "R10";
    step(1, A_ARM, 0);
    tick_n(5);
    step(1, 16'h0444, 0); step(0, A_ARM, 0); step(0, A_DIS, 0); step(1, 16'h8043, 0);
    ticks_to_expire(20, n, seen);
    chk(seen && n == 5, "R10", n, 5);
    idle(20);

    // R4: disarm stops the count
    phase = "R4";
    step(1, A_ARM, 0);
    tick_n(5);
    step(1, A_DIS, 0);
    ticks_to_expire(25, n, seen);
    chk(!seen, "R4", int'(seen), 0);

    // R11: disarm coinciding with the expiring tick
    phase = "R11";
    period_sel = 3'd0;
    step(1, A_ARM, 0);
    step(1, A_DIS, 1);
    step(0, 16'h0, 0);
    chk(rst_pulse_o == 0 && nmi_pulse_o == 0, "R11", int'(nmi_pulse_o), 0);
    ticks_to_expire(4, n, seen);
    chk(!seen, "R11", int'(seen), 0);

    // R9: period change while armed
    phase = "R9";
    period_sel = 3'd3;
    step(1, A_ARM, 0);
    tick_n(12);
    period_sel = 3'd2;
    ticks_to_expire(5, n, seen);
    chk(seen && n == 1, "R9", n, 1);
    idle(20);
    step(1, A_ARM, 0);
    tick_n(5);
    period_sel = 3'd3;
    ticks_to_expire(30, n, seen);
    chk(seen && n == 15, "R9", n, 15);
    idle(20);

    // R7: the "none" codes give no output
    phase = "R7";
    period_sel = 3'd0;
    for (int a = 2; a < 4; a++) begin
      action_sel = 2'(a);
      step(1, A_ARM, 0);
      step(0, 16'h0, 1);
      hi = 0;
      for (int i = 0; i < 20; i++) begin
        step(0, 16'h0, 0);
        if (rst_pulse_o || nmi_pulse_o) hi++;
      end
      chk(hi == 0, "R7", hi, 0);
    end

    done = 1;
    finish_run();
  end
endmodule